// File: doc/BRIEF.md
# Level-Arbitrated Vectored Interrupt Controller

This block gathers 32 level-sensitive interrupt lines and 32 software-raised interrupt bits. It masks them with an enable register, picks the pending source with the highest programmed priority level, and hands the processor a request packet. The packet carries the handler address, the register-set number, the level and a non-maskable flag, together with a request line. Each source has its own configuration word. The handler address is computed from a programmable vector-table base plus the winning index times a power-of-two entry size.

Software configures the block through a simple word-addressed port. The port takes a single-cycle write strobe and a single-cycle read strobe, and returns read data one cycle later. Set and clear aliases let software change individual enable or software-interrupt bits without a read-modify-write. The winner's index and handler address can also be read back. All outputs are registered, so the packet is stable for a full cycle and never glitches.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0, the request line is low, all packet fields are 0 and the error flag is low.
- R2: The pending word (word 35, byte 0x8C) reads (raw input status OR software bits) AND enable. Raw status (word 36) follows the input lines.
- R3: A source configuration word (words 0..31) holds the level in bits [5:0], the non-maskable flag in bit 6 and the register-set number in bits [12:7]. Bits above 12 are not stored and read 0.
- R4: The winner is the pending source with the strictly greatest level. Among equal levels the lowest index wins. A source with level 0 is never selected, even when it is pending.
- R5: The handler address is base (word 42) plus winner index times 2^(2+N), where N is bits [2:0] of the controller configuration word (word 40). Only those three bits are stored.
- R6: With a winner, the status word (41) reads the winner index with bit 31 set, word 43 reads the handler address and the request line is high. Without a winner, both words read 0, the request line is low and all packet fields are 0.
- R7: Word 32 (enable) and word 37 (software bits) take a whole-word write. Words 33 and 38 OR the written value into them, and words 34 and 39 clear the bits that are written as 1.
- R8: Writes to words 35, 36, 41 and 43 change nothing. Words 33, 34, 38 and 39 read as 0.
- R9: An access to a word index above 43, or to a byte address with bits [1:0] not zero, raises the error flag in the following cycle for one cycle. Such a read returns 0 and such a write changes nothing.
- R10: A register write is reflected in the packet one clock edge after the edge that takes the write. An input line change is reflected two edges after it is presented. Read data appears one cycle after the read strobe, and read data is 0 in any cycle that does not follow a read.
- R11: The packet's level, non-maskable flag and register-set fields come from the winning source's configuration word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 32 | Level-sensitive interrupt inputs |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read strobe |
| bus_err | output | 1 | Unmapped or misaligned access, one cycle after it |
| req_valid | output | 1 | Interrupt request to the processor |
| req_addr | output | 32 | Handler address |
| req_regset | output | 6 | Requested register set |
| req_level | output | 6 | Requested level |
| req_nmi | output | 1 | Non-maskable request flag |

## Verification
A register write taken at one edge changes the packet at the next edge. An input line passes through the raw-status register, so its effect on the packet lands two edges after it is driven. Read data and the error flag land one edge after the strobe. The bench drives on falling edges and samples on falling edges. The timing test checks that the packet has not yet changed at the first falling edge after a write or input change, and that it has changed at the edge the requirement names. Other checks wait two full cycles after their stimulus, so that every registered result has settled.

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int NSRC  = 32,
  parameter int DW    = 32,
  parameter int AW    = 8,
  parameter int LVL_W = 6,
  parameter int RS_W  = 6,
  parameter int VS_W  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_lines,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            bus_err,
  output logic            req_valid,
  output logic [DW-1:0]   req_addr,
  output logic [RS_W-1:0] req_regset,
  output logic [LVL_W-1:0] req_level,
  output logic            req_nmi
);
  localparam int IDX_W  = $clog2(NSRC);
  localparam int CFG_W  = LVL_W + 1 + RS_W;
  localparam int WIX_W  = AW - 2;
  localparam int NWORDS = NSRC + 12;
  localparam logic [WIX_W-1:0] W_EN     = WIX_W'(NSRC);
  localparam logic [WIX_W-1:0] W_ENSET  = WIX_W'(NSRC + 1);
  localparam logic [WIX_W-1:0] W_ENCLR  = WIX_W'(NSRC + 2);
  localparam logic [WIX_W-1:0] W_PEND   = WIX_W'(NSRC + 3);
  localparam logic [WIX_W-1:0] W_RAW    = WIX_W'(NSRC + 4);
  localparam logic [WIX_W-1:0] W_SW     = WIX_W'(NSRC + 5);
  localparam logic [WIX_W-1:0] W_SWSET  = WIX_W'(NSRC + 6);
  localparam logic [WIX_W-1:0] W_SWCLR  = WIX_W'(NSRC + 7);
  localparam logic [WIX_W-1:0] W_CTRL   = WIX_W'(NSRC + 8);
  localparam logic [WIX_W-1:0] W_STAT   = WIX_W'(NSRC + 9);
  localparam logic [WIX_W-1:0] W_BASE   = WIX_W'(NSRC + 10);
  localparam logic [WIX_W-1:0] W_VADDR  = WIX_W'(NSRC + 11);

  logic [CFG_W-1:0] cfg [NSRC];
  logic [NSRC-1:0]  en_q, sw_q, raw_q;
  logic [VS_W-1:0]  vsz_q;
  logic [DW-1:0]    base_q;
  logic [IDX_W-1:0] idx_q;

  logic [WIX_W-1:0] wix;
  logic             mapped;
  logic [NSRC-1:0]  pend;
  logic [LVL_W-1:0] best;
  logic [IDX_W-1:0] widx;
  logic             win;
  logic [DW-1:0]    vaddr;
  logic [DW-1:0]    rmux;

  assign wix    = bus_addr[AW-1:2];
  assign mapped = (bus_addr[1:0] == 2'b00) && (int'(wix) < NWORDS);
  assign pend   = (raw_q | sw_q) & en_q;
  assign win    = (best != '0);
  assign vaddr  = base_q + ((DW'(widx) << 2) << vsz_q);

  always_comb begin
    best = '0;
    widx = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (pend[i] && (cfg[i][LVL_W-1:0] > best)) begin
        best = cfg[i][LVL_W-1:0];
        widx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) cfg[i] <= '0;
      en_q   <= '0;
      sw_q   <= '0;
      raw_q  <= '0;
      vsz_q  <= '0;
      base_q <= '0;
    end else begin
      raw_q <= irq_lines;
      if (bus_wr && mapped) begin
        if (int'(wix) < NSRC) begin
          cfg[wix[IDX_W-1:0]] <= bus_wdata[CFG_W-1:0];
        end else begin
          case (wix)
            W_EN:    en_q   <= bus_wdata[NSRC-1:0];
            W_ENSET: en_q   <= en_q | bus_wdata[NSRC-1:0];
            W_ENCLR: en_q   <= en_q & ~bus_wdata[NSRC-1:0];
            W_SW:    sw_q   <= bus_wdata[NSRC-1:0];
            W_SWSET: sw_q   <= sw_q | bus_wdata[NSRC-1:0];
            W_SWCLR: sw_q   <= sw_q & ~bus_wdata[NSRC-1:0];
            W_CTRL:  vsz_q  <= bus_wdata[VS_W-1:0];
            W_BASE:  base_q <= bus_wdata;
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid  <= 1'b0;
      idx_q      <= '0;
      req_addr   <= '0;
      req_level  <= '0;
      req_nmi    <= 1'b0;
      req_regset <= '0;
    end else begin
      req_valid  <= win;
      idx_q      <= win ? widx : '0;
      req_addr   <= win ? vaddr : '0;
      req_level  <= best;
      req_nmi    <= win & cfg[widx][LVL_W];
      req_regset <= win ? cfg[widx][CFG_W-1:LVL_W+1] : '0;
    end
  end

  always_comb begin
    rmux = '0;
    if (int'(wix) < NSRC) begin
      rmux = DW'(cfg[wix[IDX_W-1:0]]);
    end else begin
      case (wix)
        W_EN:    rmux = DW'(en_q);
        W_PEND:  rmux = DW'(pend);
        W_RAW:   rmux = DW'(raw_q);
        W_SW:    rmux = DW'(sw_q);
        W_CTRL:  rmux = DW'(vsz_q);
        W_STAT:  rmux = {req_valid, (DW-1-IDX_W)'(0), idx_q};
        W_BASE:  rmux = base_q;
        W_VADDR: rmux = req_addr;
        default: rmux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_rdata <= (bus_rd && mapped) ? rmux : '0;
      bus_err   <= (bus_wr || bus_rd) && !mapped;
    end
  end
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk #(
  parameter int DW    = 32,
  parameter int RS_W  = 6,
  parameter int LVL_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [DW-1:0]    bus_rdata,
  input logic             bus_err,
  input logic             req_valid,
  input logic [DW-1:0]    req_addr,
  input logic [RS_W-1:0]  req_regset,
  input logic [LVL_W-1:0] req_level,
  input logic             req_nmi
);
  a_r4_level_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_level != '0));

  a_r6_idle_packet_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (req_addr == '0 && req_level == '0 && !req_nmi && req_regset == '0));

  a_r9_err_follows_access: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_wr || bus_rd));

  a_r10_rdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd) |-> (bus_rdata == '0));
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .bus_err(bus_err), .req_valid(req_valid),
  .req_addr(req_addr), .req_regset(req_regset), .req_level(req_level),
  .req_nmi(req_nmi)
);

// File: tb/vec_irq_ctrl_tb.sv
module vec_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_lines = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, req_addr;
  logic        bus_err, req_valid, req_nmi;
  logic [5:0]  req_regset, req_level;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  vec_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .req_valid(req_valid), .req_addr(req_addr), .req_regset(req_regset),
    .req_level(req_level), .req_nmi(req_nmi)
  );

  task automatic step(); @(negedge clk); endtask
  task automatic settle(); repeat (2) @(negedge clk); endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=0x%08h exp=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(string tag, logic [7:0] a, logic [31:0] exp, logic exp_err);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    chk({tag, " rdata"}, bus_rdata, exp);
    chk({tag, " err"}, 32'(bus_err), 32'(exp_err));
  endtask

  task automatic pkt(string tag, logic v, logic [31:0] a, logic [5:0] l, logic n, logic [5:0] rs);
    chk({tag, " valid"}, 32'(req_valid), 32'(v));
    chk({tag, " addr"}, req_addr, a);
    chk({tag, " level"}, 32'(req_level), 32'(l));
    chk({tag, " nmi"}, 32'(req_nmi), 32'(n));
    chk({tag, " regset"}, 32'(req_regset), 32'(rs));
  endtask

  task automatic cleanup();
    irq_lines = '0;
    wr(8'(32*4), 0);
    wr(8'(37*4), 0);
    settle();
  endtask

  task automatic t_reset();
    pkt("R1 reset packet", 0, 0, 0, 0, 0);
    chk("R1 reset err", 32'(bus_err), 0);
    rd("R1 enable", 8'(32*4), 0, 0);
    rd("R1 cfg0", 8'(0), 0, 0);
    rd("R1 base", 8'(42*4), 0, 0);
  endtask

  task automatic t_hw_irq();
    cleanup();
    wr(8'(5*4), 32'hFFFF_0000 | 32'd1219);
    rd("R3 cfg upper bits dropped", 8'(5*4), 32'd1219, 0);
    wr(8'(33*4), 32'h20);
    irq_lines[5] = 1'b1;
    settle();
    pkt("R11 hw source 5", 1, 20, 3, 1, 9);
    rd("R2 pending", 8'(35*4), 32'h20, 0);
    rd("R2 raw", 8'(36*4), 32'h20, 0);
    rd("R6 status", 8'(41*4), 32'h8000_0005, 0);
    rd("R6 vaddr", 8'(43*4), 20, 0);
  endtask

  task automatic t_timing();
    cleanup();
    wr(8'(12*4), 4);
    wr(8'(32*4), 32'h1000);
    wr(8'(38*4), 32'h1000);
    chk("R10 write not yet visible", 32'(req_valid), 0);
    step();
    pkt("R10 write one edge later", 1, 48, 4, 0, 0);
    cleanup();
    wr(8'(7*4), 2);
    wr(8'(32*4), 32'h80);
    irq_lines[7] = 1'b1;
    step();
    chk("R10 input edge 1", 32'(req_valid), 0);
    step();
    pkt("R10 input edge 2", 1, 28, 2, 0, 0);
  endtask

  task automatic t_arb();
    cleanup();
    wr(8'(2*4), 7);
    wr(8'(9*4), 647);
    wr(8'(20*4), 0);
    wr(8'(32*4), 32'hFFFF_FFFF);
    wr(8'(38*4), 32'h0010_0204);
    irq_lines[5] = 1'b1;
    settle();
    pkt("R4 tie lowest index", 1, 8, 7, 0, 0);
    wr(8'(39*4), 32'h4);
    settle();
    pkt("R4 next after clear", 1, 36, 7, 0, 5);
    wr(8'(9*4), 0);
    wr(8'(42*4), 32'h1000);
    wr(8'(40*4), 32'hFFFF_FFFB);
    settle();
    pkt("R5 base and size", 1, 32'h10A0, 3, 1, 9);
    rd("R5 ctrl stored bits", 8'(40*4), 3, 0);
    rd("R6 status winner", 8'(41*4), 32'h8000_0005, 0);
    rd("R6 vaddr winner", 8'(43*4), 32'h10A0, 0);
  endtask

  task automatic t_idle();
    irq_lines = '0;
    wr(8'(39*4), 32'hFFFF_FFFF);
    settle();
    pkt("R6 no winner", 0, 0, 0, 0, 0);
    rd("R6 status idle", 8'(41*4), 0, 0);
    rd("R6 vaddr idle", 8'(43*4), 0, 0);
    wr(8'(38*4), 32'h0010_0000);
    settle();
    chk("R4 level zero ignored", 32'(req_valid), 0);
    rd("R4 level zero pending", 8'(35*4), 32'h0010_0000, 0);
  endtask

  task automatic t_setclr();
    wr(8'(32*4), 32'hFF);
    wr(8'(34*4), 32'h0F);
    rd("R7 enable clear", 8'(32*4), 32'hF0, 0);
    wr(8'(33*4), 32'h100);
    rd("R7 enable set", 8'(32*4), 32'h1F0, 0);
    wr(8'(37*4), 32'h10);
    rd("R7 sw whole write", 8'(37*4), 32'h10, 0);
    rd("R8 enset reads 0", 8'(33*4), 0, 0);
    rd("R8 swclr reads 0", 8'(39*4), 0, 0);
  endtask

  task automatic t_readonly();
    wr(8'(35*4), 0);
    wr(8'(36*4), 32'hFF);
    wr(8'(41*4), 32'hFFFF_FFFF);
    wr(8'(43*4), 32'h1234);
    settle();
    rd("R8 pending unchanged", 8'(35*4), 32'h10, 0);
    rd("R8 raw unchanged", 8'(36*4), 0, 0);
    rd("R8 status unchanged", 8'(41*4), 0, 0);
    rd("R8 vaddr unchanged", 8'(43*4), 0, 0);
  endtask

  task automatic t_err();
    rd("R9 unmapped read", 8'(44*4), 0, 1);
    step();
    chk("R9 err one cycle", 32'(bus_err), 0);
    wr(8'h81, 32'hFFFF_FFFF);
    chk("R9 misaligned write err", 32'(bus_err), 1);
    wr(8'(63*4), 32'hFFFF_FFFF);
    chk("R9 unmapped write err", 32'(bus_err), 1);
    rd("R9 write had no effect", 8'(32*4), 32'h1F0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: act=hung exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_hw_irq();
    t_timing();
    t_arb();
    t_idle();
    t_setclr();
    t_readonly();
    t_err();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule